// File: doc/BRIEF.md
# Enable-Window Configuration Access Decoder

This block sits on the CPU I/O path and implements the older, two-register way of reaching configuration space. Software writes a one-byte enable register that carries the target function and opens a 4 KB I/O window. It also writes a one-byte target register that holds the bus number. While the window is open, every I/O access inside 0xC000–0xCFFF becomes a configuration transaction. Address bits [11:8] pick one of 16 devices and bits [7:0] pick the register. Software closes the window again by writing zero to the enable register after each access.

The block decides in the same cycle where each CPU I/O access goes. It can go to one of its own byte registers, out as a configuration transaction with byte lanes, back as an all-ones response, or unchanged to the ordinary I/O path. A byte write to a select port turns the mechanism on or off, so that on dual-mode bridges it can give way to another access scheme. Register writes take effect at the next clock edge. Read data is returned in the same cycle, right-justified in `cpu_rdata`.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the enable register, the target register and the select state are all zero, so the mechanism is active and the window is closed. Byte reads of 0xCF8 and 0xCFA return 0, and window addresses are forwarded.
- R2: A byte write (size code 0) to 0xCF8 loads the enable register and a byte write to 0xCFA loads the target bus register, both from `cpu_wdata[7:0]` and visible from the next cycle. Byte reads of these ports return the register value in `cpu_rdata[7:0]` with the upper bits zero. Writing 0x00 to both ports makes both read back 0x00.
- R3: The window is open exactly when enable bits [7:4] are nonzero. The function number is enable bits [3:1], and bit 0 has no effect. An enable value such as 0x0E keeps the window closed.
- R4: While the window is open, an access to 0xC000–0xCFFF that is not claimed by R9 or R10 raises `cfg_req` in the same cycle and does not raise `fwd_req`. It carries `cfg_dev`=addr[11:8], `cfg_dword`=addr[7:2], `cfg_bus`=target register, `cfg_func`=enable[3:1] and `cfg_wr`=`cpu_wr`.
- R5: Byte lanes follow the offset addr[1:0] and the size code (0 byte, 1 word, 2 dword). A byte enables lane addr[1:0], a word enables lanes addr[1:0] and addr[1:0]+1, and a dword enables all four. `cfg_wdata` holds the low bytes of `cpu_wdata` shifted into the enabled lanes, with the other lanes zero.
- R6: A configuration read returns the enabled lanes of `cfg_rdata` shifted down to bit 0, with the bytes beyond the access size zero. When `cfg_present` is low, every requested byte reads 0xFF.
- R7: A word at an odd offset or a dword at a nonzero offset inside the open window raises neither `cfg_req` nor `fwd_req`. Such a read returns all ones in the requested size.
- R8: While the window is closed, accesses to 0xC000–0xCFFF are forwarded unchanged, and the read data comes from `fwd_rdata`.
- R9: Byte accesses to 0xCF8 and 0xCFA reach the registers even while the window is open. Word and dword accesses at those addresses are not register accesses, so in an open window they become configuration accesses to device 12.
- R10: A byte write to 0xCFB is always claimed and never forwarded. The value 0x00 selects this mechanism, and any nonzero value deselects it. While it is deselected, byte accesses to 0xCF8 and 0xCFA and the window are forwarded. Reads of 0xCFB are decoded like any other address.
- R11: All other I/O accesses are forwarded with the same address, size, direction and data. `cfg_req` and `fwd_req` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU I/O access valid this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | I/O byte address |
| cpu_size | input | 2 | 0 byte, 1 word, 2 dword |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_rdata | output | 32 | Read data, right-justified |
| cfg_req | output | 1 | Configuration transaction valid |
| cfg_wr | output | 1 | Configuration write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 4 | Device number 0–15 |
| cfg_func | output | 3 | Function number |
| cfg_dword | output | 6 | Dword index of the register |
| cfg_be | output | 4 | Byte lane enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Lane-aligned configuration read data |
| cfg_present | input | 1 | Addressed device responds |
| fwd_req | output | 1 | Ordinary I/O access forwarded |
| fwd_wr | output | 1 | Forwarded direction |
| fwd_addr | output | 16 | Forwarded address |
| fwd_size | output | 2 | Forwarded size code |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_rdata | input | 32 | Read data of the forwarded access |

## Verification
The hardest case to reach is the overlap of the port addresses with the open window. Its outcome depends on the access size, on the direction at 0xCFB and on the select state. The stimulus therefore weights accesses toward 0xCF8, 0xCFA and 0xCFB at all three sizes, and keeps the window open most of the time by mostly writing enable values with a nonzero upper nibble. Directed steps cover the remaining cases: a word read at 0xCF8 while the window is open, the enable value 0x0E, the deselect/reselect sequence through 0xCFB, misaligned accesses and absent devices.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int PORT_W   = 8;
    localparam int DEV_W    = 4;
    localparam int REG_W    = 8;
    localparam int FUNC_W   = 3;
    localparam int LANES    = DATA_W / 8;
    localparam int OFF_W    = $clog2(LANES);
    localparam int WTAG_W   = ADDR_W - DEV_W - REG_W;
    localparam int DWIDX_W  = REG_W - OFF_W;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } io_size_e;

    typedef enum logic [2:0] {
        RT_FWD,
        RT_ENABLE,
        RT_TARGET,
        RT_SELECT,
        RT_CONFIG,
        RT_MISALIGN
    } route_e;

    typedef struct packed {
        logic [PORT_W-1:0] enable;
        logic [PORT_W-1:0] target;
        logic              other_mode;
    } regs_t;
endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs import cfgwin_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enable,
    input  logic              wr_target,
    input  logic              wr_select,
    input  logic [PORT_W-1:0] wbyte,
    output regs_t             regs_q
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_enable) r_d.enable     = wbyte;
        if (wr_target) r_d.target     = wbyte;
        if (wr_select) r_d.other_mode = (wbyte != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs_q = r_q;

    // R2
    enable_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> r_q.enable == $past(wbyte));
    // R2
    target_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_target |=> r_q.target == $past(wbyte));
    // R2
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |=> $stable(r_q.enable));
    // R10
    select_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_select |=> r_q.other_mode == ($past(wbyte) != '0));
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode import cfgwin_pkg::*; #(
    parameter logic [ADDR_W-1:0] ENABLE_PORT = 16'hCF8,
    parameter logic [ADDR_W-1:0] TARGET_PORT = 16'hCFA,
    parameter logic [ADDR_W-1:0] SELECT_PORT = 16'hCFB,
    parameter logic [WTAG_W-1:0] WIN_TAG     = 4'hC
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  io_size_e          size,
    input  regs_t             regs,
    output route_e            route
);
    logic win_open, in_win, aligned, is_byte, active;

    always_comb begin
        active   = !regs.other_mode;
        win_open = active && (regs.enable[PORT_W-1 -: 4] != '0);
        in_win   = (addr[ADDR_W-1 -: WTAG_W] == WIN_TAG);
        is_byte  = (size == SZ_BYTE);
        case (size)
            SZ_BYTE: aligned = 1'b1;
            SZ_WORD: aligned = !addr[0];
            default: aligned = (addr[OFF_W-1:0] == '0);
        endcase

        if (wr && is_byte && addr == SELECT_PORT)
            route = RT_SELECT;
        else if (active && is_byte && addr == ENABLE_PORT)
            route = RT_ENABLE;
        else if (active && is_byte && addr == TARGET_PORT)
            route = RT_TARGET;
        else if (win_open && in_win)
            route = aligned ? RT_CONFIG : RT_MISALIGN;
        else
            route = RT_FWD;
    end
endmodule

// File: rtl/cfgwin_lanes.sv
module cfgwin_lanes import cfgwin_pkg::*; (
    input  io_size_e          size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata_raw,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_lanes,
    output logic [DATA_W-1:0] rdata_just,
    output logic [DATA_W-1:0] size_mask
);
    logic [LANES-1:0]  be_base;
    logic [DATA_W-1:0] lane_mask;

    always_comb begin
        case (size)
            SZ_BYTE: be_base = LANES'(1);
            SZ_WORD: be_base = LANES'(3);
            default: be_base = '1;
        endcase
        be = be_base << off;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_mask[8*i +: 8] = {8{be[i]}};
        assign size_mask[8*i +: 8] = {8{be_base[i]}};
    end

    assign wdata_lanes = (wdata << {off, 3'b000}) & lane_mask;
    assign rdata_just  = (rdata_raw >> {off, 3'b000}) & size_mask;
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder import cfgwin_pkg::*; #(
    parameter logic [ADDR_W-1:0] ENABLE_PORT = 16'hCF8,
    parameter logic [ADDR_W-1:0] TARGET_PORT = 16'hCFA,
    parameter logic [ADDR_W-1:0] SELECT_PORT = 16'hCFB,
    parameter logic [WTAG_W-1:0] WIN_TAG     = 4'hC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [1:0]         cpu_size,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cfg_req,
    output logic               cfg_wr,
    output logic [PORT_W-1:0]  cfg_bus,
    output logic [DEV_W-1:0]   cfg_dev,
    output logic [FUNC_W-1:0]  cfg_func,
    output logic [DWIDX_W-1:0] cfg_dword,
    output logic [LANES-1:0]   cfg_be,
    output logic [DATA_W-1:0]  cfg_wdata,
    input  logic [DATA_W-1:0]  cfg_rdata,
    input  logic               cfg_present,
    output logic               fwd_req,
    output logic               fwd_wr,
    output logic [ADDR_W-1:0]  fwd_addr,
    output logic [1:0]         fwd_size,
    output logic [DATA_W-1:0]  fwd_wdata,
    input  logic [DATA_W-1:0]  fwd_rdata
);
    io_size_e          size;
    route_e            route;
    regs_t             regs;
    logic              do_wr;
    logic [DATA_W-1:0] rdata_just, size_mask;

    assign size  = io_size_e'(cpu_size);
    assign do_wr = cpu_req && cpu_wr;

    cfgwin_decode #(
        .ENABLE_PORT(ENABLE_PORT), .TARGET_PORT(TARGET_PORT),
        .SELECT_PORT(SELECT_PORT), .WIN_TAG(WIN_TAG)
    ) u_decode (
        .wr(cpu_wr), .addr(cpu_addr), .size(size), .regs(regs), .route(route)
    );

    cfgwin_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_enable(do_wr && route == RT_ENABLE),
        .wr_target(do_wr && route == RT_TARGET),
        .wr_select(do_wr && route == RT_SELECT),
        .wbyte(cpu_wdata[PORT_W-1:0]),
        .regs_q(regs)
    );

    cfgwin_lanes u_lanes (
        .size(size), .off(cpu_addr[OFF_W-1:0]), .wdata(cpu_wdata),
        .rdata_raw(cfg_rdata), .be(cfg_be), .wdata_lanes(cfg_wdata),
        .rdata_just(rdata_just), .size_mask(size_mask)
    );

    assign cfg_req   = cpu_req && route == RT_CONFIG;
    assign cfg_wr    = cpu_wr;
    assign cfg_bus   = regs.target;
    assign cfg_dev   = cpu_addr[REG_W +: DEV_W];
    assign cfg_func  = regs.enable[FUNC_W:1];
    assign cfg_dword = cpu_addr[REG_W-1:OFF_W];

    assign fwd_req   = cpu_req && route == RT_FWD;
    assign fwd_wr    = cpu_wr;
    assign fwd_addr  = cpu_addr;
    assign fwd_size  = cpu_size;
    assign fwd_wdata = cpu_wdata;

    always_comb begin
        case (route)
            RT_ENABLE:   cpu_rdata = DATA_W'(regs.enable);
            RT_TARGET:   cpu_rdata = DATA_W'(regs.target);
            RT_CONFIG:   cpu_rdata = cfg_present ? rdata_just : size_mask;
            RT_MISALIGN: cpu_rdata = size_mask;
            RT_FWD:      cpu_rdata = fwd_rdata;
            default:     cpu_rdata = '0;
        endcase
    end

    // R11
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_req && fwd_req));
    // R4
    cfg_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (regs.enable[PORT_W-1 -: 4] != '0) && !regs.other_mode);
    // R5
    cfg_lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 ||
                     $countones(cfg_be) == LANES));
    // R8
    cfg_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> cpu_addr[ADDR_W-1 -: WTAG_W] == WIN_TAG);
    // R10
    select_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_wr && cpu_size == 2'd0 && cpu_addr == SELECT_PORT) |-> !fwd_req);
endmodule

// File: tb/cfgwin_decoder_bench.sv
`timescale 1ns/1ps
module cfgwin_decoder_bench;
    logic        clk = 0, rst_n = 0;
    logic        cpu_req = 0, cpu_wr = 0;
    logic [15:0] cpu_addr = 0;
    logic [1:0]  cpu_size = 0;
    logic [31:0] cpu_wdata = 0, cpu_rdata;
    logic        cfg_req, cfg_wr;
    logic [7:0]  cfg_bus;
    logic [3:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_dword;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, cfg_rdata = 0;
    logic        cfg_present = 0;
    logic        fwd_req, fwd_wr;
    logic [15:0] fwd_addr;
    logic [1:0]  fwd_size;
    logic [31:0] fwd_wdata, fwd_rdata = 0;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] m_en = 0, m_tg = 0;
    logic       m_oth = 0;

    always #4 clk = ~clk;

    cfgwin_decoder u_cfgwin_decoder (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] base_be(input logic [1:0] sz);
        return (sz == 0) ? 4'b0001 : (sz == 1) ? 4'b0011 : 4'b1111;
    endfunction

    function automatic logic [31:0] bytes_mask(input logic [3:0] be);
        logic [31:0] m = 0;
        for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    // 0 fwd, 1 enable, 2 target, 3 select, 4 config, 5 misaligned
    function automatic int exp_route(input logic wr, input logic [15:0] a, input logic [1:0] sz);
        logic ok;
        ok = (sz == 0) || (sz == 1 && !a[0]) || (sz == 2 && a[1:0] == 0);
        if (wr && sz == 0 && a == 16'hCFB) return 3;
        if (!m_oth && sz == 0 && a == 16'hCF8) return 1;
        if (!m_oth && sz == 0 && a == 16'hCFA) return 2;
        if (!m_oth && m_en[7:4] != 0 && a[15:12] == 4'hC) return ok ? 4 : 5;
        return 0;
    endfunction

    function automatic string route_tag(input int rt, input logic [15:0] a);
        logic is_port;
        is_port = (a == 16'hCF8 || a == 16'hCFA);
        if (rt == 3) return "R10";
        if (rt == 1 || rt == 2) return (m_en[7:4] != 0) ? "R9" : "R2";
        if (rt == 5) return "R7";
        if (rt == 4) return is_port ? "R9" : "R4";
        if (m_oth && (a[15:12] == 4'hC)) return "R10";
        if (a[15:12] == 4'hC) return (m_en != 0 && m_en[7:4] == 0) ? "R3" : "R8";
        return "R11";
    endfunction

    task automatic access(input string tag_in, input logic wr, input logic [15:0] a,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input logic [31:0] crd, input logic pres, input logic [31:0] frd);
        int rt;
        string tag;
        logic [3:0] be;
        logic [31:0] smask;
        @(posedge clk); #1;
        cpu_req = 1; cpu_wr = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        cfg_rdata = crd; cfg_present = pres; fwd_rdata = frd;
        #2;
        rt    = exp_route(wr, a, sz);
        tag   = (tag_in == "") ? route_tag(rt, a) : tag_in;
        be    = base_be(sz) << a[1:0];
        smask = bytes_mask(base_be(sz));
        chk(tag, "cfg_req", cfg_req, rt == 4);
        chk(tag, "fwd_req", fwd_req, rt == 0);
        if (rt == 4) begin
            chk("R4", "cfg_bus", cfg_bus, m_tg);
            chk("R4", "cfg_dev", cfg_dev, a[11:8]);
            chk("R4", "cfg_dword", cfg_dword, a[7:2]);
            chk("R4", "cfg_wr", cfg_wr, wr);
            chk("R3", "cfg_func", cfg_func, m_en[3:1]);
            chk("R5", "cfg_be", cfg_be, be);
            if (wr) chk("R5", "cfg_wdata", cfg_wdata, (wd & smask) << (8 * a[1:0]));
            else    chk("R6", "rdata", cpu_rdata, pres ? ((crd >> (8 * a[1:0])) & smask) : smask);
        end
        if (rt == 0) begin
            chk(tag, "fwd_addr", fwd_addr, a);
            chk(tag, "fwd_size", fwd_size, sz);
            chk(tag, "fwd_wr", fwd_wr, wr);
            if (wr) chk(tag, "fwd_wdata", fwd_wdata, wd);
            else    chk(tag, "rdata", cpu_rdata, frd);
        end
        if (rt == 1 && !wr) chk(tag, "enable rd", cpu_rdata, {24'h0, m_en});
        if (rt == 2 && !wr) chk(tag, "target rd", cpu_rdata, {24'h0, m_tg});
        if (rt == 5 && !wr) chk("R7", "rdata", cpu_rdata, smask);
        if (wr && rt == 1) m_en  = wd[7:0];
        if (wr && rt == 2) m_tg  = wd[7:0];
        if (wr && rt == 3) m_oth = (wd[7:0] != 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int seed;
        seed = $urandom(32'd7715);
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        access("R1", 0, 16'hCF8, 0, 0, 0, 0, 32'h1111_2222);
        access("R1", 0, 16'hCFA, 0, 0, 0, 0, 32'h3333_4444);
        access("R1", 0, 16'hC104, 2, 0, 0, 0, 32'hABCD_0123);
        // open, function 3, bus 0x2A
        access("R2", 1, 16'hCF8, 0, 32'hFFFF_FFF6, 0, 0, 0);
        access("R2", 1, 16'hCFA, 0, 32'h0000_002A, 0, 0, 0);
        access("", 0, 16'hC310, 2, 0, 32'hDEAD_BEEF, 1, 0);
        access("", 0, 16'hC512, 1, 0, 32'h1234_5678, 0, 0);
        access("", 0, 16'hC706, 1, 0, 32'h89AB_CDEF, 1, 0);
        access("", 1, 16'hC7A3, 0, 32'h1234_565A, 0, 1, 0);
        access("", 0, 16'hC201, 1, 0, 0, 1, 0);
        access("", 1, 16'hC402, 2, 32'hCAFE_F00D, 0, 1, 0);
        access("", 0, 16'hCF8, 0, 0, 0, 1, 0);
        access("", 0, 16'hCF8, 1, 0, 32'h7777_8888, 1, 0);
        access("", 0, 16'hCFB, 0, 0, 32'h0102_0304, 1, 0);
        // R3 upper nibble zero keeps window closed
        access("R3", 1, 16'hCF8, 0, 32'h0E, 0, 0, 0);
        access("", 0, 16'hC300, 2, 0, 0, 1, 32'h5555_AAAA);
        access("R2", 1, 16'hCF8, 0, 32'hF2, 0, 0, 0);
        // R10 deselect, then reselect
        access("R10", 1, 16'hCFB, 0, 32'h01, 0, 0, 0);
        access("R10", 0, 16'hCF8, 0, 0, 0, 0, 32'h0000_00EE);
        access("R10", 0, 16'hC300, 2, 0, 0, 1, 32'h0BAD_CAFE);
        access("R10", 1, 16'hCFB, 0, 32'h00, 0, 0, 0);
        access("", 0, 16'hC300, 2, 0, 32'h4433_2211, 1, 0);
        // close both and read back zero (R2)
        access("R2", 1, 16'hCF8, 0, 32'h00, 0, 0, 0);
        access("R2", 1, 16'hCFA, 0, 32'h00, 0, 0, 0);
        access("R2", 0, 16'hCF8, 0, 0, 0, 0, 0);
        access("R2", 0, 16'hCFA, 0, 0, 0, 0, 0);
        access("R11", 0, 16'h03F8, 0, 0, 0, 0, 32'h0000_0061);
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int cat;
            logic [15:0] a;
            logic [1:0] sz;
            logic [31:0] wd;
            logic wr;
            cat = $urandom % 12;
            sz  = 2'($urandom % 3);
            wr  = 1'($urandom % 2);
            wd  = $urandom;
            case (cat)
                0, 1: begin
                    a = 16'hCF8; sz = 0;
                    case ($urandom % 4)
                        0, 1: wd[7:0] = 8'hF0 | 8'($urandom % 8) << 1 | 8'($urandom % 2);
                        2:    wd[7:0] = 8'h00;
                        default: ;
                    endcase
                end
                2: begin a = 16'hCFA; sz = 0; end
                3: begin
                    a = 16'hCFB; sz = ($urandom % 2) ? 2'd0 : sz;
                    wd[7:0] = (($urandom % 5) == 0) ? 8'h01 : 8'h00;
                end
                4: a = ($urandom % 2) ? 16'hCF8 : 16'hCFA;
                10, 11: a = 16'($urandom);
                default: a = 16'hC000 | 16'($urandom % 4096);
            endcase
            access("", wr, a, sz, wd, $urandom, 1'($urandom % 4 != 0), $urandom);
        end
        @(posedge clk); #1 cpu_req = 0;
        summary();
    end
endmodule